// File: doc/BRIEF.md
# Container DMA Command Issuer

This block drives the command side of one DMA channel that moves a 4 KiB container between a local buffer and system memory. Software supplies a 64-bit container descriptor as two 32-bit words. The block splits it into two 44-bit, 64-byte-aligned physical addresses: one for the container status flag and one for the container buffer. When the run input is set, the block reads the status flag. If the flag does not yet show the state the channel needs, the block waits a programmable number of cycles and reads it again. Once the flag is right, the block streams 64 data bursts of 64 bytes each. It keeps up to four bursts in flight, and each burst carries a tag that names the channel and one of four burst slots.

Responses may come back in any order, and each one frees the slot named in its tag. When all bursts have been retired, the block writes the flag to its opposite state. After the response to that write, it pulses a done interrupt. A receive-direction channel (IS_RX=1) waits for an empty flag (0), writes the bursts to memory and then marks the flag full (1). A transmit-direction channel (IS_RX=0) waits for a full flag (1), reads the bursts and then marks the flag empty (0).

The interconnect is represented by a valid/ready command port and a valid-only response port.

Top module: `container_dma_issuer`

The FSM states are:
- ST_IDLE
- ST_POLL_REQ: issue the flag read.
- ST_POLL_WAIT: wait for the flag read response.
- ST_POLL_GAP: wait out the poll period.
- ST_XFER: issue data bursts.
- ST_DRAIN: wait for outstanding bursts.
- ST_FLAG_REQ: issue the flag write.
- ST_FLAG_WAIT: wait for the flag write response.
- ST_DONE: interrupt cycle.

The FSM transitions are:
- IDLE→POLL_REQ on run.
- POLL_REQ→POLL_WAIT on command accept.
- POLL_WAIT→XFER on a wanted flag.
- POLL_WAIT→POLL_GAP on an unwanted flag.
- POLL_GAP→POLL_REQ, or POLL_GAP→IDLE if run is low, when the timer expires.
- XFER→DRAIN when all 64 bursts are issued or run is low.
- DRAIN→FLAG_REQ when all slots are free and all 64 bursts were issued.
- DRAIN→IDLE when all slots are free and fewer than 64 bursts were issued.
- FLAG_REQ→FLAG_WAIT on command accept.
- FLAG_WAIT→DONE on the response.
- DONE→IDLE.

## Requirements
- R1: While reset is held, and after it is released with run low, cmd_valid and irq_done are 0.
- R2: The flag address is {desc_hi[31:20], desc_lo[25:0], 6'b0}. The buffer base address is {desc_hi[31:20], desc_hi[19:0], desc_lo[31:26], 6'b0}. Every command address has bits 5:0 equal to zero.
- R3: When run rises from idle, the first command is a flag read: cmd_kind=0, cmd_write=0, address = flag address, cmd_tag={CHAN,2'b00}.
- R4: When a flag read response carries an unwanted value, cmd_valid stays low for exactly poll_period+1 cycles and then the flag read is issued again. The wanted value is 1 when IS_RX=0 and 0 when IS_RX=1.
- R5: After a wanted flag value, 64 data bursts are issued (cmd_kind=1, cmd_write=IS_RX). Burst n has address buffer base + 64*n, and cmd_tag[3:2]=CHAN.
- R6: At most 4 data bursts are outstanding. With 4 unretired bursts, cmd_valid is 0.
- R7: A response retires the burst whose slot is in rsp_tag[1:0], in any order. A response whose rsp_tag[3:2] differs from CHAN frees no slot. A new burst never uses a slot that is still outstanding.
- R8: After all 64 bursts retire, a flag write is issued: cmd_kind=2, cmd_write=1, cmd_flag = the opposite of the wanted value, address = flag address, tag={CHAN,2'b00}. The cycle after its response, irq_done is 1 for exactly one cycle.
- R9: With run low, no data burst is offered. After a stop, the outstanding bursts retire and the block goes idle with no flag write and no interrupt.
- R10: While cmd_valid is high and cmd_ready is low with run high, cmd_valid, cmd_addr, cmd_tag and cmd_kind are unchanged in the next cycle.
- R11: cmd_src equals IS_RX on every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Channel enable |
| desc_lo | input | 32 | Descriptor bits 31:0 |
| desc_hi | input | 32 | Descriptor bits 63:32 |
| poll_period | input | PERIOD_W | Wait cycles between flag reads |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_kind | output | 2 | 0 flag read, 1 data burst, 2 flag write |
| cmd_write | output | 1 | Command writes memory |
| cmd_flag | output | 1 | Flag value for a flag write |
| cmd_addr | output | 44 | Physical address |
| cmd_tag | output | 4 | {channel, burst slot} |
| cmd_src | output | 1 | Direction bit (1 = receive) |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | 4 | Tag of the response |
| rsp_flag | input | 1 | Flag value on a flag read response |
| irq_done | output | 1 | Container finished pulse |

## Verification
A wrong slot bitmap shows up at the command port as soon as the next burst is offered. It appears either as a tag reused while still outstanding, or as cmd_valid staying low with free slots left. This is caught within the round of four bursts where it happens. A wrong burst counter shows up as a burst address off its 64-byte stride, or as a flag write issued too early or too late. A poll timer that is off by one changes the measured gap by one cycle on the very next retry. A stuck FSM shows up as a missing interrupt pulse or as commands issued after a stop.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    localparam int ADDR_W = 44;
    localparam int EXT_W  = 12;
    localparam int FLD_W  = 26;

    typedef enum logic [3:0] {
        ST_IDLE, ST_POLL_REQ, ST_POLL_WAIT, ST_POLL_GAP, ST_XFER,
        ST_DRAIN, ST_FLAG_REQ, ST_FLAG_WAIT, ST_DONE
    } cdma_state_e;

    localparam logic [1:0] KIND_FLAG_RD = 2'd0;
    localparam logic [1:0] KIND_DATA    = 2'd1;
    localparam logic [1:0] KIND_FLAG_WR = 2'd2;
endpackage

// File: rtl/cdesc_decode.sv
module cdesc_decode
    import cdma_pkg::*;
(
    input  logic [31:0]       lo_word,
    input  logic [31:0]       hi_word,
    output logic [ADDR_W-1:0] flag_addr,
    output logic [ADDR_W-1:0] base_addr
);
    logic [63:0]      packed_desc;
    logic [EXT_W-1:0] ext_bits;
    logic [FLD_W-1:0] flag_fld;
    logic [FLD_W-1:0] base_fld;

    always_comb begin
        packed_desc = {hi_word, lo_word};
        ext_bits    = packed_desc[63:52];
        base_fld    = packed_desc[51:26];
        flag_fld    = packed_desc[25:0];
        flag_addr   = {ext_bits, flag_fld, 6'b0};
        base_addr   = {ext_bits, base_fld, 6'b0};
    end
endmodule

// File: rtl/burst_slot_pool.sv
module burst_slot_pool #(
    parameter int SLOTS = 4,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             retire,
    input  logic [IDX_W-1:0] retire_idx,
    output logic [IDX_W-1:0] free_idx,
    output logic             any_free,
    output logic             all_free
);
    logic [SLOTS-1:0] busy;
    logic [SLOTS-1:0] set_mask;
    logic [SLOTS-1:0] clr_mask;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        all_free = (busy == '0);
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_mask
        assign set_mask[g] = alloc  && (alloc_idx  == IDX_W'(g));
        assign clr_mask[g] = retire && (retire_idx == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] period,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= period;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/container_dma_issuer.sv
module container_dma_issuer
    import cdma_pkg::*;
#(
    parameter logic [1:0] CHAN            = 2'd0,
    parameter bit         IS_RX           = 1'b0,
    parameter int         PERIOD_W        = 16,
    parameter int         SLOTS           = 4,
    parameter int         BURST_BYTES     = 64,
    parameter int         CONTAINER_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [31:0]         desc_lo,
    input  logic [31:0]         desc_hi,
    input  logic [PERIOD_W-1:0] poll_period,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [1:0]          cmd_kind,
    output logic                cmd_write,
    output logic                cmd_flag,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [3:0]          cmd_tag,
    output logic                cmd_src,
    input  logic                rsp_valid,
    input  logic [3:0]          rsp_tag,
    input  logic                rsp_flag,
    output logic                irq_done
);
    localparam int BURSTS    = CONTAINER_BYTES / BURST_BYTES;
    localparam int CNT_W     = $clog2(BURSTS + 1);
    localparam int IDX_W     = $clog2(SLOTS);
    localparam int OFS_W     = $clog2(BURST_BYTES);
    localparam bit WANT_FLAG = !IS_RX;

    cdma_state_e state, state_n;

    logic [ADDR_W-1:0] flag_addr, base_addr, data_addr;
    logic [CNT_W-1:0]  issued;
    logic [IDX_W-1:0]  free_idx, tag_sel, hold_idx, slot;
    logic              any_free, all_free, hold_vld;
    logic              rsp_mine, retire_hit, data_go, data_hs, gap_load, gap_done;
    logic              all_issued;

    cdesc_decode u_dec (
        .lo_word(desc_lo), .hi_word(desc_hi),
        .flag_addr(flag_addr), .base_addr(base_addr)
    );

    assign rsp_mine   = rsp_valid && (rsp_tag[3:2] == CHAN);
    assign retire_hit = rsp_mine && (state == ST_XFER || state == ST_DRAIN);
    assign all_issued = (issued == CNT_W'(BURSTS));
    assign data_go    = (state == ST_XFER) && run && any_free && !all_issued;
    assign data_hs    = data_go && cmd_ready;
    assign tag_sel    = hold_vld ? hold_idx : free_idx;
    assign data_addr  = base_addr + (ADDR_W'(issued) << OFS_W);
    assign gap_load   = (state == ST_POLL_WAIT) && rsp_mine && (rsp_flag != WANT_FLAG);

    burst_slot_pool #(.SLOTS(SLOTS)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc(data_hs), .alloc_idx(tag_sel),
        .retire(retire_hit), .retire_idx(rsp_tag[IDX_W-1:0]),
        .free_idx(free_idx), .any_free(any_free), .all_free(all_free)
    );

    poll_timer #(.W(PERIOD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .period(poll_period), .expired(gap_done)
    );

    // State register and burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            issued   <= '0;
            hold_vld <= 1'b0;
            hold_idx <= '0;
        end else begin
            state <= state_n;
            if (state == ST_POLL_WAIT) issued <= '0;
            else if (data_hs)          issued <= issued + 1'b1;
            if (data_go && !cmd_ready) begin
                hold_vld <= 1'b1;
                hold_idx <= tag_sel;
            end else begin
                hold_vld <= 1'b0;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      if (run) state_n = ST_POLL_REQ;
            ST_POLL_REQ:  if (cmd_ready) state_n = ST_POLL_WAIT;
            ST_POLL_WAIT: if (rsp_mine)
                              state_n = (rsp_flag == WANT_FLAG) ? ST_XFER : ST_POLL_GAP;
            ST_POLL_GAP:  if (gap_done) state_n = run ? ST_POLL_REQ : ST_IDLE;
            ST_XFER:      if (!run || all_issued) state_n = ST_DRAIN;
            ST_DRAIN:     if (all_free) state_n = all_issued ? ST_FLAG_REQ : ST_IDLE;
            ST_FLAG_REQ:  if (cmd_ready) state_n = ST_FLAG_WAIT;
            ST_FLAG_WAIT: if (rsp_mine) state_n = ST_DONE;
            ST_DONE:      state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_kind  = KIND_FLAG_RD;
        cmd_write = 1'b0;
        cmd_flag  = 1'b0;
        cmd_addr  = flag_addr;
        slot      = '0;
        irq_done  = 1'b0;
        unique case (state)
            ST_POLL_REQ: cmd_valid = 1'b1;
            ST_XFER: begin
                cmd_valid = data_go;
                cmd_kind  = KIND_DATA;
                cmd_write = IS_RX;
                cmd_addr  = data_addr;
                slot      = tag_sel;
            end
            ST_FLAG_REQ: begin
                cmd_valid = 1'b1;
                cmd_kind  = KIND_FLAG_WR;
                cmd_write = 1'b1;
                cmd_flag  = !WANT_FLAG;
            end
            ST_DONE: irq_done = 1'b1;
            default: ;
        endcase
        cmd_tag = {CHAN, 2'(slot)};
        cmd_src = IS_RX;
    end
endmodule

// File: rtl/container_dma_issuer_chk.sv
module container_dma_issuer_chk #(
    parameter logic [1:0] CHAN  = 2'd0,
    parameter bit         IS_RX = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [1:0]  cmd_kind,
    input logic [43:0] cmd_addr,
    input logic [3:0]  cmd_tag,
    input logic        cmd_src,
    input logic        rsp_valid,
    input logic [3:0]  rsp_tag,
    input logic        irq_done
);
    logic [3:0] out_mask, out_mask_n;
    logic       data_hs;

    assign data_hs = cmd_valid && cmd_ready && (cmd_kind == 2'd1);

    always_comb begin
        out_mask_n = out_mask;
        if (rsp_valid && rsp_tag[3:2] == CHAN) out_mask_n[rsp_tag[1:0]] = 1'b0;
        if (data_hs) out_mask_n[cmd_tag[1:0]] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_mask <= '0;
        else        out_mask <= out_mask_n;
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_addr[5:0] == 6'd0); // R2

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (!run || (cmd_valid && $stable(cmd_addr)
            && $stable(cmd_tag) && $stable(cmd_kind)))); // R10

    AST_SLOT_NOT_REUSED: assert property (@(posedge clk) disable iff (!rst_n)
        data_hs |-> !out_mask[cmd_tag[1:0]]); // R7

    AST_TAG_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_tag[3:2] == CHAN); // R5

    AST_SRC_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_src == IS_RX); // R11

    AST_FLAG_WR_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |-> out_mask == 4'd0); // R8

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done); // R8

    AST_NO_BURST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd1) |-> run); // R9
endmodule

bind container_dma_issuer container_dma_issuer_chk #(.CHAN(CHAN), .IS_RX(IS_RX)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_tag(cmd_tag), .cmd_src(cmd_src),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .irq_done(irq_done)
);

// File: tb/container_dma_issuer_test.sv
module container_dma_issuer_test;
    localparam logic [1:0] TCH = 2'd2;

    // {desc_lo, desc_hi, flag address, buffer base}
    localparam logic [151:0] VEC [0:2] = '{
        {32'h0000_0001, 32'h0000_0000, 44'h000_0000_0040, 44'h000_0000_0000},
        {32'hFC00_0000, 32'hABC0_0000, 44'hABC_0000_0000, 44'hABC_0000_0FC0},
        {32'h0BAD_F00D, 32'h1234_5678, 44'h123_EB7C_0340, 44'h123_4567_8080}
    };

    logic        clk = 1'b0;
    logic        rst_n, run, cmd_ready, rsp_valid, rsp_flag;
    logic [31:0] desc_lo, desc_hi;
    logic [15:0] poll_period;
    logic [3:0]  rsp_tag;
    logic        cmd_valid, cmd_write, cmd_flag, cmd_src, irq_done;
    logic [1:0]  cmd_kind;
    logic [43:0] cmd_addr;
    logic [3:0]  cmd_tag;

    int checks = 0;
    int fails  = 0;

    logic [1:0]  c_kind;
    logic [43:0] c_addr;
    logic [3:0]  c_tag;
    logic        c_write, c_flag, c_src;

    always #5 clk = ~clk;

    container_dma_issuer #(.CHAN(TCH), .IS_RX(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .desc_lo(desc_lo), .desc_hi(desc_hi),
        .poll_period(poll_period), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_write(cmd_write), .cmd_flag(cmd_flag),
        .cmd_addr(cmd_addr), .cmd_tag(cmd_tag), .cmd_src(cmd_src),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_flag(rsp_flag),
        .irq_done(irq_done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cmd();
        int n = 0;
        while (!cmd_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!cmd_valid) check(1'b0, "R5 command timeout", 64'd0, 64'd1);
    endtask

    task automatic take_cmd();
        wait_cmd();
        c_kind = cmd_kind; c_addr = cmd_addr; c_tag = cmd_tag;
        c_write = cmd_write; c_flag = cmd_flag; c_src = cmd_src;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic respond(input logic [3:0] tag, input logic flag);
        rsp_valid = 1'b1; rsp_tag = tag; rsp_flag = flag;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run = 1'b0; cmd_ready = 1'b0; rsp_valid = 1'b0;
        rsp_flag = 1'b0; rsp_tag = '0; desc_lo = '0; desc_hi = '0;
        poll_period = 16'd3;
        repeat (3) @(negedge clk);
        check(!cmd_valid && !irq_done, "R1 in reset", {cmd_valid, irq_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!cmd_valid && !irq_done, "R1 after reset", {cmd_valid, irq_done}, 0);

        // Table walk: decode, first poll, first burst, stop
        for (int v = 0; v < 3; v++) begin
            logic [43:0] e_flag, e_base;
            bit quiet;
            desc_lo = VEC[v][151:120];
            desc_hi = VEC[v][119:88];
            e_flag  = VEC[v][87:44];
            e_base  = VEC[v][43:0];
            run = 1'b1;
            take_cmd();
            check(c_addr == e_flag, "R2 flag address", c_addr, e_flag);
            check(c_kind == 2'd0 && !c_write && c_tag == {TCH, 2'b00},
                  "R3 first poll", {c_kind, c_write, c_tag}, {2'd0, 1'b0, TCH, 2'b00});
            check(c_src == 1'b0, "R11 poll source", c_src, 0);
            respond({TCH, 2'b00}, 1'b1);
            take_cmd();
            check(c_addr == e_base, "R2 buffer base", c_addr, e_base);
            check(c_kind == 2'd1 && !c_write, "R5 burst kind", {c_kind, c_write}, {2'd1, 1'b0});
            run = 1'b0;
            respond(c_tag, 1'b0);
            quiet = 1'b1;
            for (int k = 0; k < 8; k++) begin
                if (cmd_valid || irq_done) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R9 stop idles", {63'd0, quiet}, 1);
        end

        // Full container with a rejected poll
        begin
            logic [43:0] e_flag, e_base;
            logic [3:0]  busy;
            logic [3:0]  rec [4];
            int gap;
            desc_lo = VEC[2][151:120];
            desc_hi = VEC[2][119:88];
            e_flag  = VEC[2][87:44];
            e_base  = VEC[2][43:0];
            busy = '0;
            run = 1'b1;
            take_cmd();
            respond({TCH, 2'b00}, 1'b0);
            gap = 0;
            while (!cmd_valid && gap < 100) begin
                gap++;
                @(negedge clk);
            end
            check(gap == 4, "R4 poll gap", gap, 4);
            take_cmd();
            check(c_kind == 2'd0 && c_addr == e_flag, "R4 repoll", c_addr, e_flag);
            respond({TCH, 2'b00}, 1'b1);

            for (int r = 0; r < 16; r++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [43:0] e_addr;
                    wait_cmd();
                    if (r == 0 && k == 0) begin
                        logic [43:0] a0;
                        logic [3:0]  t0;
                        bit held;
                        a0 = cmd_addr; t0 = cmd_tag; held = 1'b1;
                        for (int h = 0; h < 3; h++) begin
                            @(negedge clk);
                            if (!cmd_valid || cmd_addr != a0 || cmd_tag != t0) held = 1'b0;
                        end
                        check(held, "R10 held command", {63'd0, held}, 1);
                    end
                    take_cmd();
                    e_addr = e_base + 44'(64 * (r * 4 + k));
                    check(c_addr == e_addr, "R5 burst address", c_addr, e_addr);
                    check(c_tag[3:2] == TCH && !busy[c_tag[1:0]], "R7 free slot tag",
                          {c_tag, busy}, {TCH, 2'b00, 4'b0000});
                    busy[c_tag[1:0]] = 1'b1;
                    rec[k] = c_tag;
                end
                check(!cmd_valid, "R6 four outstanding", cmd_valid, 0);
                if (r == 0) begin
                    respond({2'b01, 2'b00}, 1'b0);
                    check(!cmd_valid, "R7 foreign tag ignored", cmd_valid, 0);
                end
                respond(rec[2], 1'b0);
                respond(rec[0], 1'b0);
                respond(rec[3], 1'b0);
                respond(rec[1], 1'b0);
                busy = '0;
            end

            take_cmd();
            check(c_kind == 2'd2 && c_write && !c_flag && c_addr == e_flag
                  && c_tag == {TCH, 2'b00}, "R8 flag write",
                  {c_kind, c_write, c_flag, c_addr}, {2'd2, 1'b1, 1'b0, e_flag});
            check(!irq_done, "R8 no early irq", irq_done, 0);
            respond({TCH, 2'b00}, 1'b0);
            check(irq_done, "R8 irq pulse", irq_done, 1);
            run = 1'b0;
            @(negedge clk);
            check(!irq_done, "R8 irq one cycle", irq_done, 0);
        end

        // Reset in the middle of a poll wait
        run = 1'b1;
        take_cmd();
        rst_n = 1'b0;
        @(negedge clk);
        check(!cmd_valid && !irq_done, "R1 mid-run reset", {cmd_valid, irq_done}, 0);
        run = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule